// File: doc/BRIEF.md
# Vertical-Sync-Clocked Display ID Streamer

This block sends a monitor's display identification buffer toward the host one bit at a time. The monitor's vertical sync pulse acts as the bit clock, and the block runs only while no bidirectional host link is active. The VCLK input is asynchronous to the system clock, so the block synchronizes it and acts on each rising edge. Every byte takes nine VCLK periods. Eight of them drive the data bits, most-significant first. In the ninth the data line is released. The next byte then starts at once, so the stream never pauses.

The buffer itself is outside the block. The block supplies a 7-bit read address. A combinational read port returns the addressed byte on `rd_data`. In the idle ninth slot the address advances and `rd_req` strobes for one cycle, which gives the new byte several cycles to settle before its first bit is taken. The address wraps after 128 bytes, so the buffer repeats for as long as the enable stays high. At the launch of each byte's last bit, `irq` pulses for one cycle so that firmware can follow the progress.

The data line is an open-drain style pair. `sda_oe` enables the pad driver and `sda_out` is the value it drives.

Top module: `edid_vsync_tx`

## Requirements
- R1: While `tx_en` is low, `sda_oe` is low. Dropping `tx_en` in the middle of a byte releases the line on the next clock.
- R2: `vclk_in` passes through a two-stage synchronizer and rising-edge detection. When a rising clock edge first samples `vclk_in` high after it was low, the line state changes on the second rising clock edge after that one.
- R3: Slots 0 to 7 of a byte drive bits 7 down to 0 with `sda_oe` high. The byte is the value on `rd_data` when slot 0 starts.
- R4: Slot 8 of every byte drives `sda_oe` low, so one byte spans nine VCLK rising edges.
- R5: The VCLK rising edge after slot 8 launches bit 7 of the next byte, with no extra idle slot.
- R6: `rd_req` is a one-cycle pulse when slot 8 starts, and `rd_addr` increments by one in that same cycle. `rd_addr` changes at no other time.
- R7: `irq` is a one-cycle pulse in the cycle that bit 0 (slot 7) is launched. It never coincides with `rd_req`.
- R8: `rd_addr` wraps from 127 to 0.
- R9: While `tx_en` is low the slot counter returns to 0 and `rd_addr` holds. After re-enabling, the first VCLK edge sends bit 7 of the byte at the held address.
- R10: After reset, `sda_oe`, `sda_out`, `rd_req` and `irq` are low and `rd_addr` is 0.
- R11: `sda_out` is low whenever `sda_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vclk_in | input | 1 | Vertical sync used as bit clock (asynchronous) |
| tx_en | input | 1 | Transmit enable |
| rd_data | input | 8 | Byte from buffer read port at `rd_addr` |
| rd_addr | output | 7 | Buffer read address |
| rd_req | output | 1 | Byte request / address advance strobe |
| sda_oe | output | 1 | Data line driver enable |
| sda_out | output | 1 | Data line drive value |
| irq | output | 1 | Byte progress interrupt pulse |

## Verification
Every line result is due two clock edges after the edge that first samples VCLK high. `rd_req`, `irq` and the address step are registered on that same edge. A change of `tx_en` shows up on the very next edge. The bench runs a behavioural model that keeps a sample history of `vclk_in`. At each edge the model applies an update only when its history shows the rise with exactly that delay. The model and the design are compared on the falling edge of every cycle, so each check samples a settled value one edge after it was due. VCLK periods vary, and the enable drops mid-byte and inside the idle slot, so the slot reset and address hold are seen at the ports.

// File: rtl/edid_tx_pkg.sv
package edid_tx_pkg;
    parameter int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int SLOT_W = 4;
    localparam logic [SLOT_W-1:0] SLOT_IDLE = SLOT_W'(BYTE_W);
    localparam logic [SLOT_W-1:0] SLOT_LSB  = SLOT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [BYTE_W-2:0] rest;
        logic [ADDR_W-1:0] addr;
        logic              oe;
        logic              dout;
        logic              req;
        logic              irq;
    } seq_state_t;
endpackage

// File: rtl/vclk_edge_sync.sv
module vclk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R2: a detected rise lasts exactly one cycle
    p_single_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/edid_bit_seq.sv
module edid_bit_seq
    import edid_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [ADDR_W-1:0] addr,
    output logic              req,
    output logic              oe,
    output logic              dout,
    output logic              irq
);
    seq_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        st_d.irq = 1'b0;
        if (!en) begin
            st_d.slot = '0;
            st_d.oe   = 1'b0;
            st_d.dout = 1'b0;
        end else if (tick) begin
            if (st_q.slot == SLOT_IDLE) begin
                st_d.oe   = 1'b0;
                st_d.dout = 1'b0;
                st_d.req  = 1'b1;
                st_d.addr = st_q.addr + 1'b1;
                st_d.slot = '0;
            end else begin
                st_d.oe = 1'b1;
                if (st_q.slot == '0) begin
                    st_d.dout = byte_in[BYTE_W-1];
                    st_d.rest = byte_in[BYTE_W-2:0];
                end else begin
                    st_d.dout = st_q.rest[BYTE_W-2];
                    st_d.rest = {st_q.rest[BYTE_W-3:0], 1'b0};
                end
                st_d.irq  = (st_q.slot == SLOT_LSB);
                st_d.slot = st_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr = st_q.addr;
    assign req  = st_q.req;
    assign oe   = st_q.oe;
    assign dout = st_q.dout;
    assign irq  = st_q.irq;

    p_release_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !oe);
    p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
    p_addr_only_on_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != $past(addr)) |-> req);
    p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (addr == ADDR_W'($past(addr) + 1'b1)));
    p_irq_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && req));
    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    p_idle_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !oe);
    p_quiet_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !dout);
endmodule

// File: rtl/edid_vsync_tx.sv
module edid_vsync_tx
    import edid_tx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vclk_in,
    input  logic              tx_en,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_req,
    output logic              sda_oe,
    output logic              sda_out,
    output logic              irq
);
    logic vclk_rise;

    vclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (vclk_in),
        .rise     (vclk_rise)
    );

    edid_bit_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (vclk_rise),
        .en      (tx_en),
        .byte_in (rd_data),
        .addr    (rd_addr),
        .req     (rd_req),
        .oe      (sda_oe),
        .dout    (sda_out),
        .irq     (irq)
    );
endmodule

// File: tb/sim_edid_vsync_tx.sv
`timescale 1ns/1ps
module sim_edid_vsync_tx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vclk_in = 1'b0;
    logic tx_en = 1'b0;
    logic [7:0] rd_data;
    logic [6:0] rd_addr;
    logic rd_req, sda_oe, sda_out, irq;

    logic [7:0] mem [128];
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign rd_data = mem[rd_addr];

    edid_vsync_tx u0 (
        .clk(clk), .rst_n(rst_n), .vclk_in(vclk_in), .tx_en(tx_en),
        .rd_data(rd_data), .rd_addr(rd_addr), .rd_req(rd_req),
        .sda_oe(sda_oe), .sda_out(sda_out), .irq(irq)
    );

    // behavioural reference model
    bit hist[$];
    int m_slot, m_addr;
    bit [7:0] m_byte;
    bit e_oe, e_out, e_req, e_irq;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            hist = {1'b0, 1'b0, 1'b0};
            m_slot = 0; m_addr = 0; m_byte = 0;
            e_oe = 0; e_out = 0; e_req = 0; e_irq = 0;
        end else begin
            hist.push_back(vclk_in);
            if (hist.size() > 8) void'(hist.pop_front());
            e_req = 0; e_irq = 0;
            if (!tx_en) begin
                m_slot = 0; e_oe = 0; e_out = 0;
            end else if (hist[hist.size()-3] && !hist[hist.size()-4]) begin
                if (m_slot == 8) begin
                    e_oe = 0; e_out = 0; e_req = 1;
                    m_addr = (m_addr + 1) % 128;
                    m_slot = 0;
                end else begin
                    if (m_slot == 0) m_byte = mem[m_addr];
                    e_oe = 1;
                    e_out = m_byte[7 - m_slot];
                    e_irq = (m_slot == 7);
                    m_slot++;
                end
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1/R4 sda_oe", sda_oe, e_oe);
            chk("R3/R5 sda_out", sda_out, e_out);
            chk("R6 rd_req", rd_req, e_req);
            chk("R7 irq", irq, e_irq);
            chk("R8 rd_addr", rd_addr, m_addr);
        end
    end

    task automatic vclk_periods(int n, int half);
        for (int i = 0; i < n; i++) begin
            int h;
            h = half + (i % 3);
            vclk_in = 1'b1;
            repeat (h) @(negedge clk);
            vclk_in = 1'b0;
            repeat (h) @(negedge clk);
        end
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 8'((i * 37 + 5) ^ (i >> 2));
        repeat (4) @(negedge clk);
        // R10: reset values
        chk("R10 sda_oe", sda_oe, 0);
        chk("R10 sda_out", sda_out, 0);
        chk("R10 rd_req", rd_req, 0);
        chk("R10 irq", irq, 0);
        chk("R10 rd_addr", rd_addr, 0);
        rst_n = 1'b1;
        // R1: edges with enable low leave the line released
        vclk_periods(5, 3);
        chk("R1 released while disabled", sda_oe, 0);
        tx_en = 1'b1;
        vclk_periods(40, 3);             // several bytes, R3 R4 R5 R6 R7
        vclk_in = 1'b1;
        repeat (2) @(negedge clk);
        tx_en = 1'b0;                    // R1 R9 drop mid-byte
        @(negedge clk);
        chk("R1 release next clock", sda_oe, 0);
        chk("R11 low when released", sda_out, 0);
        vclk_periods(4, 4);
        tx_en = 1'b1;                    // R9 resume at bit 7
        vclk_periods(9 * 140, 2);        // R8 wrap past 127
        tx_en = 1'b0;
        vclk_periods(2, 3);
        repeat (6) @(negedge clk);
        done = 1;
    end

    initial begin
        while (!done && cycles < 150000) @(negedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected 1 (run completed)", 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule